// File: doc/BRIEF.md
# Serial Port Configuration Registers and Bit-Rate Generator

This block is the byte-wide register front end of a serial port. Software writes a 16-bit rate divisor through two byte registers, a status register that holds the double-speed and multiprocessor-mode selections, and two control registers that carry the enables and the character-size code. From these the block derives a bit-rate tick, the receiver and transmitter enables, and the character length in bits. Shift registers, parity and interrupt arbitration sit outside and only consume these outputs. In the other direction, two status inputs let them raise the transmit-complete flag and drop the data-empty flag.

Every accepted write that alters the line configuration produces a single-cycle `cfg_change` pulse. Some registers compare only their configuration bits against the stored value. The others pulse on every write. The same pulse restarts the bit-rate counter, so a new divisor or speed takes effect from a fresh, full period.

Register addresses: 0 status, 1 control B, 2 control C, 3 divisor low byte, 4 divisor high byte. Reads of addresses 5 to 7 return zero.

Top module: `uart_cfg_top`

## Requirements
- R1: After reset, `tx_en`, `rx_en`, `cfg_change` and `baud_tick` are low, the status register reads 0x20 (data-empty flag only), and every other register reads 0x00.
- R2: A write to the status register stores only bit 1 (double speed) and bit 0 (multiprocessor mode). Writing 1 at bit 6 clears the transmit-complete flag, which `txc_set` raises. Reads show transmit-complete at bit 6 and data-empty at bit 5. Bit 7 and bits 4..2 read zero.
- R3: The divisor is {high byte, low byte}. The bit period is F x (divisor + 1) clocks, with F = 8 when status bit 1 is set and F = 16 otherwise.
- R4: A status write pulses `cfg_change` only when bit 1 differs from its stored value.
- R5: A control B write pulses `cfg_change` only when bit 4, bit 3 or bit 2 differs from its stored value. Other bit changes and identical rewrites give no pulse.
- R6: Every write to control C or to either divisor byte pulses `cfg_change`, even when the value is unchanged.
- R7: `rx_en` equals control B bit 4 and `tx_en` equals control B bit 3. Control B and C read back as written.
- R8: A write that sets control B bit 3 from 0 sets the data-empty flag. This takes priority over `dre_clr` in the same cycle. `dre_clr` clears the flag otherwise.
- R9: `char_bits` is decoded from the code {control B bit 2, control C bits 2:1}: 0→5, 1→6, 2→7, 3→8, 7→9. Codes 4 to 6 report 8.
- R10: The cycle in which `cfg_change` is high carries no tick. The first `baud_tick` comes exactly one bit period after that cycle, and later ticks follow every bit period.
- R11: `cfg_change` is a one-cycle pulse, high in the cycle after the clock edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, accepted on the rising clock edge |
| txc_set | input | 1 | Raises the transmit-complete flag |
| dre_clr | input | 1 | Clears the data-empty flag |
| rdata | output | 8 | Read data for `addr` (combinational) |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| char_bits | output | 4 | Character length in bits |
| cfg_change | output | 1 | One-cycle configuration-change pulse |
| baud_tick | output | 1 | One-cycle pulse per bit period |

## Verification
Register contents, enables, `char_bits` and `cfg_change` all become valid one cycle after the write edge. `rdata` follows `addr` within the same cycle. The bench drives inputs on the falling edge and samples on the falling edge that follows the accepting rising edge, so every check lands in the cycle where its result is due. The first bit tick is due a full period after the strobe cycle. The bench counts falling edges from that strobe cycle up to the tick, and then counts one more interval, and compares both counts with F x (divisor + 1).

// File: rtl/uart_cfg_pkg.sv
package uart_cfg_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int DIV_W  = 2 * DATA_W;
    localparam int PER_W  = DIV_W + 5;

    typedef enum logic [ADDR_W-1:0] {
        SEL_STAT = 3'd0,
        SEL_CTLB = 3'd1,
        SEL_CTLC = 3'd2,
        SEL_DIVL = 3'd3,
        SEL_DIVH = 3'd4,
        SEL_NONE5 = 3'd5,
        SEL_NONE6 = 3'd6,
        SEL_NONE7 = 3'd7
    } reg_sel_e;

    // status register bit positions
    localparam int ST_MPM  = 0;
    localparam int ST_DBL  = 1;
    localparam int ST_DRE  = 5;
    localparam int ST_TXC  = 6;

    // control B bit positions
    localparam int CB_SZ2  = 2;
    localparam int CB_TXON = 3;
    localparam int CB_RXON = 4;

    localparam logic [DATA_W-1:0] CB_CFG_MASK =
        DATA_W'((1 << CB_SZ2) | (1 << CB_TXON) | (1 << CB_RXON));

    typedef struct packed {
        logic [DIV_W-1:0] divisor;
        logic             dbl;
    } rate_cfg_t;

    function automatic logic [3:0] char_len(input logic [2:0] code);
        logic [3:0] n;
        case (code)
            3'd0:    n = 4'd5;
            3'd1:    n = 4'd6;
            3'd2:    n = 4'd7;
            3'd3:    n = 4'd8;
            3'd7:    n = 4'd9;
            default: n = 4'd8;
        endcase
        return n;
    endfunction

    function automatic logic [PER_W-1:0] bit_period(input rate_cfg_t c);
        logic [PER_W-1:0] base;
        base = {{(PER_W-DIV_W){1'b0}}, c.divisor} + PER_W'(1);
        return c.dbl ? (base << 3) : (base << 4);
    endfunction

endpackage

// File: rtl/uart_cfg_regs.sv
module uart_cfg_regs
    import uart_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              txc_set,
    input  logic              dre_clr,
    output logic [DATA_W-1:0] rdata,
    output logic              cfg_change,
    output logic              tx_en,
    output logic              rx_en,
    output logic [2:0]        size_code,
    output rate_cfg_t         rate_cfg
);

    reg_sel_e          sel;
    logic [1:0]        stat_keep;
    logic              txc_flag;
    logic              dre_flag;
    logic [DATA_W-1:0] ctl_b;
    logic [DATA_W-1:0] ctl_c;
    logic [DATA_W-1:0] div_lo;
    logic [DATA_W-1:0] div_hi;
    logic              strobe_d;
    logic              tx_rise;

    assign sel = reg_sel_e'(addr);

    always_comb begin
        strobe_d = 1'b0;
        if (wr_en) begin
            case (sel)
                SEL_STAT: strobe_d = (wdata[ST_DBL] != stat_keep[ST_DBL]);
                SEL_CTLB: strobe_d = ((wdata & CB_CFG_MASK) != (ctl_b & CB_CFG_MASK));
                SEL_CTLC, SEL_DIVL, SEL_DIVH: strobe_d = 1'b1;
                default:  strobe_d = 1'b0;
            endcase
        end
    end

    assign tx_rise = wr_en && (sel == SEL_CTLB) && wdata[CB_TXON] && !ctl_b[CB_TXON];

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_keep  <= '0;
            txc_flag   <= 1'b0;
            dre_flag   <= 1'b1;
            ctl_b      <= '0;
            ctl_c      <= '0;
            div_lo     <= '0;
            div_hi     <= '0;
            cfg_change <= 1'b0;
        end else begin
            cfg_change <= strobe_d;
            if (wr_en) begin
                case (sel)
                    SEL_STAT: stat_keep <= wdata[1:0];
                    SEL_CTLB: ctl_b     <= wdata;
                    SEL_CTLC: ctl_c     <= wdata;
                    SEL_DIVL: div_lo    <= wdata;
                    SEL_DIVH: div_hi    <= wdata;
                    default:  ;
                endcase
            end
            if (txc_set)
                txc_flag <= 1'b1;
            else if (wr_en && sel == SEL_STAT && wdata[ST_TXC])
                txc_flag <= 1'b0;
            if (tx_rise)
                dre_flag <= 1'b1;
            else if (dre_clr)
                dre_flag <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_STAT: begin
                rdata[ST_TXC]      = txc_flag;
                rdata[ST_DRE]      = dre_flag;
                rdata[ST_DBL:ST_MPM] = stat_keep;
            end
            SEL_CTLB: rdata = ctl_b;
            SEL_CTLC: rdata = ctl_c;
            SEL_DIVL: rdata = div_lo;
            SEL_DIVH: rdata = div_hi;
            default:  rdata = '0;
        endcase
    end

    assign tx_en            = ctl_b[CB_TXON];
    assign rx_en            = ctl_b[CB_RXON];
    assign size_code        = {ctl_b[CB_SZ2], ctl_c[2:1]};
    assign rate_cfg.divisor = {div_hi, div_lo};
    assign rate_cfg.dbl     = stat_keep[ST_DBL];

    AST_STROBE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        cfg_change |-> $past(wr_en)); // R11

    AST_CTLC_ALWAYS_STROBES: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == SEL_CTLC) |=> cfg_change); // R6

    AST_STAT_SAME_DBL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == SEL_STAT && wdata[ST_DBL] == rdata[ST_DBL]) |=> !cfg_change); // R4

    AST_CTLB_SAME_CFG_QUIET: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == SEL_CTLB && ((wdata ^ ctl_b) & CB_CFG_MASK) == '0) |=> !cfg_change); // R5

    AST_TXEN_SETS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_en) |-> dre_flag); // R8

endmodule

// File: rtl/uart_rate_gen.sv
module uart_rate_gen
    import uart_cfg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rate_cfg_t rate_cfg,
    input  logic      restart,
    output logic      tick
);

    logic [PER_W-1:0] period;
    logic [PER_W-1:0] cnt;
    logic             at_end;

    assign period = bit_period(rate_cfg);
    assign at_end = (cnt == period - PER_W'(1));

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (at_end)
            cnt <= '0;
        else
            cnt <= cnt + PER_W'(1);
    end

    assign tick = at_end && !restart;

    AST_COUNT_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
        !restart |-> (cnt < period)); // R3

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(restart) |-> (cnt == '0)); // R10

endmodule

// File: rtl/uart_cfg_top.sv
module uart_cfg_top
    import uart_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              txc_set,
    input  logic              dre_clr,
    output logic [DATA_W-1:0] rdata,
    output logic              tx_en,
    output logic              rx_en,
    output logic [3:0]        char_bits,
    output logic              cfg_change,
    output logic              baud_tick
);

    rate_cfg_t  rate_cfg;
    logic [2:0] size_code;

    uart_cfg_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .addr       (addr),
        .wdata      (wdata),
        .wr_en      (wr_en),
        .txc_set    (txc_set),
        .dre_clr    (dre_clr),
        .rdata      (rdata),
        .cfg_change (cfg_change),
        .tx_en      (tx_en),
        .rx_en      (rx_en),
        .size_code  (size_code),
        .rate_cfg   (rate_cfg)
    );

    uart_rate_gen u_rate (
        .clk      (clk),
        .rst      (rst),
        .rate_cfg (rate_cfg),
        .restart  (cfg_change),
        .tick     (baud_tick)
    );

    assign char_bits = char_len(size_code);

    AST_CHAR_RANGE: assert property (@(posedge clk) disable iff (rst)
        (char_bits >= 4'd5) && (char_bits <= 4'd9)); // R9

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (cfg_change && !$past(wr_en, 1)) |-> 1'b0); // R11

endmodule

// File: tb/sim_uart_cfg_top.sv
`timescale 1ns/1ps
module sim_uart_cfg_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] addr;
    logic [7:0] wdata;
    logic       wr_en;
    logic       txc_set;
    logic       dre_clr;
    logic [7:0] rdata;
    logic       tx_en;
    logic       rx_en;
    logic [3:0] char_bits;
    logic       cfg_change;
    logic       baud_tick;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    uart_cfg_top u0 (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .txc_set(txc_set), .dre_clr(dre_clr), .rdata(rdata), .tx_en(tx_en),
        .rx_en(rx_en), .char_bits(char_bits), .cfg_change(cfg_change),
        .baud_tick(baud_tick)
    );

    typedef struct packed {
        logic [2:0] a;
        logic [7:0] d;
        logic       stb;
        logic [7:0] rd;
        logic       tx;
        logic       rx;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 8'h02, 1'b1, 8'h22, 1'b0, 1'b0},
        '{3'd0, 8'h02, 1'b0, 8'h22, 1'b0, 1'b0},
        '{3'd0, 8'hFF, 1'b0, 8'h23, 1'b0, 1'b0},
        '{3'd0, 8'h01, 1'b1, 8'h21, 1'b0, 1'b0},
        '{3'd1, 8'h04, 1'b1, 8'h04, 1'b0, 1'b0},
        '{3'd1, 8'h04, 1'b0, 8'h04, 1'b0, 1'b0},
        '{3'd1, 8'hE7, 1'b0, 8'hE7, 1'b0, 1'b0},
        '{3'd1, 8'h08, 1'b1, 8'h08, 1'b1, 1'b0},
        '{3'd2, 8'h06, 1'b1, 8'h06, 1'b1, 1'b0},
        '{3'd2, 8'h06, 1'b1, 8'h06, 1'b1, 1'b0},
        '{3'd3, 8'h05, 1'b1, 8'h05, 1'b1, 1'b0},
        '{3'd4, 8'h00, 1'b1, 8'h00, 1'b1, 1'b0},
        '{3'd1, 8'h18, 1'b1, 8'h18, 1'b1, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    function automatic string strobe_tag(input logic [2:0] a);
        if (a == 3'd0) return "R4";
        if (a == 3'd1) return "R5";
        return "R6";
    endfunction

    task automatic measure(input int exp_period, input string req);
        int n;
        n = 0;
        while (n < 5000) begin
            @(negedge clk);
            n++;
            if (baud_tick) break;
        end
        check({req, " first tick"}, n, exp_period);
        n = 0;
        while (n < 5000) begin
            @(negedge clk);
            n++;
            if (baud_tick) break;
        end
        check({req, " tick interval"}, n, exp_period);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        rst = 1'b1; addr = '0; wdata = '0; wr_en = 1'b0; txc_set = 1'b0; dre_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, v); check("R1 status", v, 8'h20);
        for (int i = 1; i < 5; i++) begin
            rd(3'(i), v); check("R1 reg", v, 8'h00);
        end
        check("R1 tx_en", tx_en, 0);
        check("R1 rx_en", rx_en, 0);
        check("R1 cfg_change", cfg_change, 0);
        check("R1 baud_tick", baud_tick, 0);

        // table walk: strobe rules, storage, enables
        for (int i = 0; i < NV; i++) begin
            wr(VECS[i].a, VECS[i].d);
            check(strobe_tag(VECS[i].a), cfg_change, VECS[i].stb);
            check("R7 tx_en", tx_en, VECS[i].tx);
            check("R7 rx_en", rx_en, VECS[i].rx);
            rd(VECS[i].a, v);
            check(VECS[i].a == 3'd0 ? "R2 readback" : "R7 readback", v, VECS[i].rd);
        end

        // R11 pulse width
        wr(3'd2, 8'h06);
        check("R11 pulse high", cfg_change, 1);
        @(negedge clk);
        check("R11 pulse low", cfg_change, 0);

        // R9 character length decode
        check("R9 code 3", char_bits, 8);
        wr(3'd1, 8'h1C); check("R9 code 7", char_bits, 9);
        wr(3'd2, 8'h00); check("R9 code 4", char_bits, 8);
        wr(3'd1, 8'h18); check("R9 code 0", char_bits, 5);
        wr(3'd2, 8'h02); check("R9 code 1", char_bits, 6);
        wr(3'd2, 8'h04); check("R9 code 2", char_bits, 7);

        // R8 data-empty flag
        @(negedge clk); dre_clr = 1'b1;
        @(negedge clk); dre_clr = 1'b0;
        rd(3'd0, v); check("R8 cleared", v[5], 0);
        wr(3'd1, 8'h10);
        rd(3'd0, v); check("R8 stays clear", v[5], 0);
        wr(3'd1, 8'h18);
        rd(3'd0, v); check("R8 set by enable", v[5], 1);

        // R2 transmit-complete flag
        @(negedge clk); txc_set = 1'b1;
        @(negedge clk); txc_set = 1'b0;
        rd(3'd0, v); check("R2 txc set", v, 8'h61);
        wr(3'd0, 8'h01);
        rd(3'd0, v); check("R2 txc kept", v, 8'h61);
        wr(3'd0, 8'h41);
        rd(3'd0, v); check("R2 txc cleared", v, 8'h21);

        // R3 / R10 bit period and restart
        wr(3'd0, 8'h00);
        wr(3'd3, 8'h02);
        wr(3'd4, 8'h00);
        check("R10 no tick in strobe cycle", baud_tick, 0);
        measure(48, "R3 x16 div2");
        wr(3'd0, 8'h02);
        measure(24, "R10 x8 div2");
        wr(3'd3, 8'h00);
        wr(3'd4, 8'h01);
        measure(2056, "R3 x8 div256");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule